// File: doc/BRIEF.md
# Serial Channel FIFO Register Block

This block is the host-facing register window of one serial channel. It owns a transmit FIFO, which the host fills and the serial engine drains, and a receive FIFO, which the serial engine fills and the host drains. Each FIFO has its own almost-empty and almost-full levels. Software writes these levels into a threshold register, but they take effect only when that FIFO is cleared through the control register.

The host sees four 32-bit words. The shared data word routes host writes into the transmit FIFO and serves host reads from the receive FIFO. The control/status word takes two self-clearing clear commands and returns two active-low four-bit flag nibbles. The serial engine side is a push port and a pop port with live flag nibbles. Host reads are registered: the value is on `bus_rdata` after the clock edge that samples `bus_rd`, and it holds until the next read.

Top module: `chan_fifo_regs`

## Requirements
- R1: Word 0 is the Tx threshold register and word 1 is the Rx threshold register. In each, bits 15..0 give the almost-empty level and bits 31..16 give the almost-full level. Both registers read back exactly what was written.
- R2: A host write to word 2 pushes `bus_wdata[7:0]` into the Tx FIFO. `tx_data` shows the oldest entry, and `tx_pop` removes it, in first-in first-out order.
- R3: `rx_push` stores `rx_data` in the Rx FIFO. A host read of word 2 pops the oldest Rx entry and returns it zero-extended.
- R4: A push into a full FIFO (256 entries by default) is dropped, and the stored contents are unchanged.
- R5: A host read of word 2 with the Rx FIFO empty returns the last value popped, or 0 after reset, and the FIFO stays empty. A `tx_pop` with the Tx FIFO empty is ignored.
- R6: Writing 1 to bit 0 of word 3 empties the Tx FIFO, and writing 1 to bit 1 empties the Rx FIFO. Each bit reads back as 1 for exactly the one cycle after the write, then clears itself. The FIFO is empty from the following edge. Writing 0 has no effect.
- R7: When a clear takes effect, a nonzero threshold register loads that FIFO's levels. A zero register keeps the previous levels. After power-up both levels are 16.
- R8: Each flag nibble is active low, with bit 3 = full, bit 2 = almost full, bit 1 = almost empty and bit 0 = empty. Almost empty holds when the FIFO is empty, or when it is not full and the fill count is at or below the almost-empty level. Almost full holds when the FIFO is full, or when almost empty does not hold and free space is at or below the almost-full level.
- R9: A flag nibble only ever takes the values 0xC, 0xD, 0xF, 0xB or 0x3.
- R10: Word 3 reads the Tx nibble in bits 11..8 and the Rx nibble in bits 15..12, with the pending clear bits in 1..0 and zeros elsewhere. `tx_flags_n` and `rx_flags_n` show the same nibbles, updated every cycle.
- R11: A host read updates `bus_rdata` at the clock edge that samples `bus_rd`, and `bus_rdata` holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 2 | Host word address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered host read data |
| tx_pop | input | 1 | Serial engine removes Tx head |
| tx_data | output | DW | Tx FIFO head entry |
| tx_flags_n | output | 4 | Tx active-low flag nibble |
| rx_push | input | 1 | Serial engine stores an Rx entry |
| rx_data | input | DW | Rx entry to store |
| rx_flags_n | output | 4 | Rx active-low flag nibble |

## Verification
The hardest states to reach are levels that are loaded but never yet applied, and almost-empty and almost-full levels that overlap. Reaching them takes a threshold write, then a clear, then hundreds of pushes, so the bench walks each FIFO from empty to full and back.

It first confirms that a zero threshold register leaves the old levels in place. It then checks that overlapping levels of 200 and 200 still produce only the legal nibbles. A long pseudo-random phase then pushes and pops both FIFOs in the same cycles, including at the full and empty boundaries. A cycle-level queue model checks that phase on every clock.

// File: rtl/chan_fifo_regs.sv
module chan_fifo_regs #(
  parameter int DEPTH    = 256,
  parameter int DW       = 8,
  parameter int INIT_LVL = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_data,
  output logic [3:0]    tx_flags_n,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  output logic [3:0]    rx_flags_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] A_TXTHR = 2'd0;
  localparam logic [1:0] A_RXTHR = 2'd1;
  localparam logic [1:0] A_DATA  = 2'd2;
  localparam logic [1:0] A_CTRL  = 2'd3;

  logic [1:0][31:0]   thr_q;
  logic [1:0]         clr_v;
  logic [1:0]         push_v, pop_v, nonempty_v;
  logic [1:0][DW-1:0] din_v, head_v;
  logic [1:0][3:0]    nib_v;
  logic [DW-1:0]      rx_last;
  logic [31:0]        rd_mux;

  wire host_data_wr = bus_wr && bus_addr == A_DATA;
  wire host_data_rd = bus_rd && bus_addr == A_DATA;

  // index 0 = transmit, index 1 = receive
  assign push_v = {rx_push, host_data_wr};
  assign pop_v  = {host_data_rd, tx_pop};
  assign din_v  = {rx_data, bus_wdata[DW-1:0]};

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_fifo
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [15:0]   ae_l, af_l;
    logic          full, empty, ae_t, af_t, do_push, do_pop;
    logic [31:0]   fill, room;

    assign empty   = cnt == '0;
    assign full    = cnt == CW'(DEPTH);
    assign do_push = push_v[g] && !full;
    assign do_pop  = pop_v[g] && !empty;
    assign fill    = 32'(cnt);
    assign room    = 32'(DEPTH) - fill;
    assign ae_t    = empty || (!full && fill <= 32'(ae_l));
    assign af_t    = full || (!ae_t && room <= 32'(af_l));

    assign nib_v[g]      = {~full, ~af_t, ~ae_t, ~empty};
    assign head_v[g]     = mem[rp];
    assign nonempty_v[g] = !empty;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp   <= '0;
        rp   <= '0;
        cnt  <= '0;
        ae_l <= 16'(INIT_LVL);
        af_l <= 16'(INIT_LVL);
      end else if (clr_v[g]) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
        if (thr_q[g] != 32'h0) begin
          ae_l <= thr_q[g][15:0];
          af_l <= thr_q[g][31:16];
        end
      end else begin
        if (do_push) wp <= nxt(wp);
        if (do_pop)  rp <= nxt(rp);
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
    end

    always_ff @(posedge clk) begin
      if (do_push && !clr_v[g]) mem[wp] <= din_v[g];
    end
  end

  always_comb begin
    case (bus_addr)
      A_TXTHR: rd_mux = thr_q[0];
      A_RXTHR: rd_mux = thr_q[1];
      A_DATA:  rd_mux = nonempty_v[1] ? 32'(head_v[1]) : 32'(rx_last);
      default: rd_mux = {16'h0, nib_v[1], nib_v[0], 6'h0, clr_v};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q     <= '0;
      clr_v     <= '0;
      rx_last   <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == A_TXTHR) thr_q[0] <= bus_wdata;
      if (bus_wr && bus_addr == A_RXTHR) thr_q[1] <= bus_wdata;
      clr_v <= (bus_wr && bus_addr == A_CTRL) ? bus_wdata[1:0] : 2'b00;
      if (bus_rd) bus_rdata <= rd_mux;
      if (host_data_rd && nonempty_v[1]) rx_last <= head_v[1];
    end
  end

  assign tx_data    = head_v[0];
  assign tx_flags_n = nib_v[0];
  assign rx_flags_n = nib_v[1];
endmodule

// File: rtl/chan_fifo_regs_chk.sv
module chan_fifo_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic       tx_pop,
  input logic       rx_push,
  input logic [3:0] tx_flags_n,
  input logic [3:0] rx_flags_n,
  input logic [1:0] clr_v
);
  assert_legal_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flags_n inside {4'hC, 4'hD, 4'hF, 4'hB, 4'h3});

  assert_legal_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flags_n inside {4'hC, 4'hD, 4'hF, 4'hB, 4'h3});

  assert_tx_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_v[0] |=> tx_flags_n == 4'hC);

  assert_rx_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_v[1] |=> rx_flags_n == 4'hC);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flags_n == 4'h3 && bus_wr && bus_addr == 2'd2 && !tx_pop && !clr_v[0])
    |=> tx_flags_n == 4'h3);

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flags_n == 4'hC && bus_rd && bus_addr == 2'd2 && !rx_push && !clr_v[1])
    |=> rx_flags_n == 4'hC);
endmodule

bind chan_fifo_regs chan_fifo_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .tx_pop(tx_pop), .rx_push(rx_push),
  .tx_flags_n(tx_flags_n), .rx_flags_n(rx_flags_n), .clr_v(clr_v)
);

// File: tb/tb_chan_fifo_regs.sv
module tb_chan_fifo_regs;
  localparam int DEPTH = 256;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0, tx_pop = 0, rx_push = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [7:0]  rx_data = 0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic [3:0]  tx_flags_n, rx_flags_n;

  chan_fifo_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_flags_n(tx_flags_n),
    .rx_push(rx_push), .rx_data(rx_data), .rx_flags_n(rx_flags_n)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R8";
  logic [7:0]  txq[$], rxq[$];
  int          tae = 16, taf = 16, rae = 16, raf = 16;
  logic [31:0] thr0 = 0, thr1 = 0, exp_rd = 0;
  logic        p0 = 0, p1 = 0;
  logic [7:0]  rlast = 0;
  logic [15:0] lf = 16'hACE1;

  function automatic logic [3:0] nib(int n, int ae, int af);
    bit e, f, aet, aft;
    e = (n == 0);
    f = (n == DEPTH);
    aet = e || (!f && n <= ae);
    aft = f || (!aet && (DEPTH - n) <= af);
    return {~f, ~aft, ~aet, ~e};
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit wr, bit rd, logic [1:0] a, logic [31:0] wd, bit tp, bit rp, logic [7:0] rdin);
    logic [31:0] rv;
    bit can;
    bit seen;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    tx_pop = tp; rx_push = rp; rx_data = rdin;
    @(posedge clk);
    case (a)
      2'd0: rv = thr0;
      2'd1: rv = thr1;
      2'd2: rv = (rxq.size() > 0) ? {24'h0, rxq[0]} : {24'h0, rlast};
      default: rv = {16'h0, nib(rxq.size(), rae, raf), nib(txq.size(), tae, taf), 6'h0, p1, p0};
    endcase
    seen = rd;
    if (rd) exp_rd = rv;
    if (p0) begin
      txq.delete();
      if (thr0 != 0) begin tae = int'(thr0[15:0]); taf = int'(thr0[31:16]); end
    end else begin
      can = txq.size() < DEPTH;
      if (tp && txq.size() > 0) void'(txq.pop_front());
      if (wr && a == 2'd2 && can) txq.push_back(wd[7:0]);
    end
    if (rd && a == 2'd2 && rxq.size() > 0) rlast = rxq[0];
    if (p1) begin
      rxq.delete();
      if (thr1 != 0) begin rae = int'(thr1[15:0]); raf = int'(thr1[31:16]); end
    end else begin
      can = rxq.size() < DEPTH;
      if (rd && a == 2'd2 && rxq.size() > 0) void'(rxq.pop_front());
      if (rp && can) rxq.push_back(rdin);
    end
    if (wr && a == 2'd0) thr0 = wd;
    if (wr && a == 2'd1) thr1 = wd;
    p0 = wr && a == 2'd3 && wd[0];
    p1 = wr && a == 2'd3 && wd[1];
    @(negedge clk);
    chk("tx flags", {28'h0, tx_flags_n}, {28'h0, nib(txq.size(), tae, taf)});
    chk("rx flags", {28'h0, rx_flags_n}, {28'h0, nib(rxq.size(), rae, raf)});
    if (txq.size() > 0) chk("tx head", {24'h0, tx_data}, {24'h0, txq[0]});
    chk("read data", bus_rdata, exp_rd);
    if (!seen) exp_rd = bus_rdata === exp_rd ? exp_rd : exp_rd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 2'd0, 0, 0, 0, 8'h0);
  endtask
  task automatic wr(logic [1:0] a, logic [31:0] d);
    cyc(1, 0, a, d, 0, 0, 8'h0);
  endtask
  task automatic rdreg(logic [1:0] a);
    cyc(0, 1, a, 0, 0, 0, 8'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R8";
    chk("reset tx nibble", {28'h0, tx_flags_n}, 32'hC);
    chk("reset rx nibble", {28'h0, rx_flags_n}, 32'hC);
    chk("reset rdata", bus_rdata, 32'h0);

    tag = "R10"; rdreg(2'd3);
    chk("status word", bus_rdata, 32'h0000_CC00);

    tag = "R1";
    wr(2'd0, 32'h0020_0008);
    wr(2'd1, 32'h0000_0000);
    rdreg(2'd0);
    chk("tx thr readback", bus_rdata, 32'h0020_0008);
    rdreg(2'd1);

    tag = "R11"; idle(2);
    chk("rdata holds", bus_rdata, 32'h0);

    tag = "R2";
    for (int i = 0; i < 5; i++) wr(2'd2, 32'hA0 + i);
    chk("tx head first", {24'h0, tx_data}, 32'hA0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 2'd0, 0, 1, 0, 8'h0);

    tag = "R6";
    for (int i = 0; i < 3; i++) wr(2'd2, 32'h11 + i);
    wr(2'd3, 32'h0);
    chk("zero write keeps tx", {28'h0, tx_flags_n}, 32'hD);
    wr(2'd3, 32'h1);
    rdreg(2'd3);
    chk("pending bit seen", bus_rdata & 32'h3, 32'h1);
    chk("tx empty after clear", {28'h0, tx_flags_n}, 32'hC);
    rdreg(2'd3);
    chk("pending bit gone", bus_rdata & 32'h3, 32'h0);

    tag = "R7";
    for (int i = 0; i < 9; i++) wr(2'd2, 32'h40 + i);
    chk("ae level 8 loaded", {28'h0, tx_flags_n}, 32'hF);
    for (int i = 9; i < DEPTH - 32; i++) wr(2'd2, i);
    chk("af level 32 loaded", {28'h0, tx_flags_n}, 32'hB);
    for (int i = DEPTH - 32; i < DEPTH; i++) wr(2'd2, i);
    tag = "R4";
    for (int i = 0; i < 3; i++) wr(2'd2, 32'hEE);
    chk("tx full", {28'h0, tx_flags_n}, 32'h3);
    tag = "R5";
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 2'd0, 0, 1, 0, 8'h0);
    chk("tx empty after drain", {28'h0, tx_flags_n}, 32'hC);

    tag = "R7";
    wr(2'd3, 32'h2);
    idle(1);
    for (int i = 0; i < 17; i++) cyc(0, 0, 2'd0, 0, 0, 1, 8'h30 + i[7:0]);
    chk("rx default level kept", {28'h0, rx_flags_n}, 32'hF);
    tag = "R3";
    for (int i = 0; i < 17; i++) rdreg(2'd2);
    chk("rx last popped", bus_rdata, 32'h40);
    tag = "R5";
    rdreg(2'd2); rdreg(2'd2);
    chk("empty read repeats last", bus_rdata, 32'h40);
    tag = "R4";
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 2'd0, 0, 0, 1, i[7:0]);
    chk("rx full", {28'h0, rx_flags_n}, 32'h3);
    tag = "R3";
    for (int i = 0; i < 4; i++) rdreg(2'd2);
    chk("rx fourth entry", bus_rdata, 32'h3);

    tag = "R8";
    wr(2'd0, 32'h00C8_00C8);
    wr(2'd3, 32'h3);
    idle(1);
    for (int i = 0; i < 150; i++) wr(2'd2, i);
    chk("overlap: almost empty wins", {28'h0, tx_flags_n}, 32'hD);
    for (int i = 150; i < 210; i++) wr(2'd2, i);
    chk("above ae: almost full", {28'h0, tx_flags_n}, 32'hB);

    tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], lf[1] & lf[2], 2'd2, {24'h0, lf[15:8]}, lf[3] | lf[4], lf[5] & lf[6], lf[11:4]);
      checks++;
      if (!(tx_flags_n inside {4'hC, 4'hD, 4'hF, 4'hB, 4'h3})) begin
        errors++;
        $display("FAIL R9 legal code: actual %h expected one of C D F B 3", tx_flags_n);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule